// File: doc/BRIEF.md
# Programmable External Bus Timing Sequencer

This block turns single internal read or write requests into timed cycles on a parallel external memory bus. A cycle walks through four phases in a fixed order (address setup, address hold, data wait, data hold). Each phase has a programmable length, and reads and writes take their lengths from separate timing words. The level of every strobe pin (chip select, output enable, write, address latch) in every phase comes from a per-direction level table. The block contains no fixed strobe logic.

Mode inputs choose between a shared (multiplexed) and a separate address/data arrangement, and between an 8-bit and a 16-bit data path. The 16-bit path is legal only in multiplexed mode. Further mode inputs set a read-only restriction, shortening of write cycles by skipping their data hold phase, a one-cycle delay on output enable, halving of the address on 16-bit buses, and keeping the last read value on the data pins while idle. The configuration inputs must stay stable while a cycle is in progress. The data pins are modelled as separate out, in and enable signals. The address width must be at least the data width.

Top module: `ebus_seq`

## Requirements
- R1: After reset, and whenever no cycle is running, all four strobe pins are high, `req_done` and `req_err` are low, and the data pins are released unless R7 applies.
- R2: An accepted request passes through address setup, address hold, data wait and data hold in that order. It enters address setup on the clock after `req_start`. A phase with count N lasts N+1 cycles. In a timing word, bits [3:0] give the address setup count, [7:4] the address hold count, [21:16] the 6-bit data wait count and [11:8] the data hold count.
- R3: During a phase, each strobe pin takes the level-table bit at index 4*s+p, where s is 0 for chip select, 1 for output enable, 2 for write and 3 for address latch, and p is 0 to 3 in phase order. A 1 drives the pin high. Reads use `cfg_rd_levels` and writes use `cfg_wr_levels`.
- R4: A read samples `bus_din` on the last cycle of data wait and presents that value on `req_rdata` from the cycle of `req_done` until the next read.
- R5: `req_done` is high for exactly one cycle, in the cycle after the last cycle of the final phase. A `req_start` that arrives while a cycle is running is ignored.
- R6: With `cfg_wdh_inhibit` set, a write ends after data wait and skips data hold. Reads are unaffected.
- R7: With `cfg_keep_last` set, the idle data pins are enabled and carry the most recent read value. With it clear, they are released.
- R8: With `cfg_rdonly` set, a write request raises `req_done` and `req_err` together on the next clock, and no strobe leaves its idle level. Reads still run normally.
- R9: In multiplexed mode, the data pins carry the address during both address phases. From data wait onward they carry the write data, or are released for a read. In non-multiplexed mode, a write drives its data during all four phases and a read keeps the data pins released. `bus_addr` carries the address throughout the cycle.
- R10: With `cfg_oe_delay` set, output enable goes low only in a cycle where the table asks for low and the table also asked for low in the previous cycle of the same request.
- R11: In 8-bit mode (`cfg_wide` = 0), the upper data byte is driven as zero and the upper byte of read data returns zero. With `cfg_wide` and `cfg_ashift` both set, the request address is shifted right by one before it is placed on the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_start | input | 1 | Request strobe, taken when idle |
| req_write | input | 1 | 1 = write request |
| req_addr | input | AW | Request address |
| req_wdata | input | DW | Write data |
| req_rdata | output | DW | Last read data |
| req_done | output | 1 | One-cycle completion pulse |
| req_err | output | 1 | Write refused in read-only mode |
| cfg_wide | input | 1 | 16-bit data path |
| cfg_mux | input | 1 | Address and data share data pins |
| cfg_ashift | input | 1 | Halve address when wide |
| cfg_rdonly | input | 1 | Refuse writes |
| cfg_wdh_inhibit | input | 1 | Skip data hold on writes |
| cfg_oe_delay | input | 1 | Delay output enable by one cycle |
| cfg_keep_last | input | 1 | Drive last read value when idle |
| cfg_rd_timing | input | 22 | Read phase counts |
| cfg_wr_timing | input | 22 | Write phase counts |
| cfg_rd_levels | input | 16 | Read strobe level table |
| cfg_wr_levels | input | 16 | Write strobe level table |
| bus_cs_n | output | 1 | Chip select pin |
| bus_oe_n | output | 1 | Output enable pin |
| bus_wr_n | output | 1 | Write pin |
| bus_ale | output | 1 | Address latch pin |
| bus_addr | output | AW | Address pins |
| bus_dout | output | DW | Data pins, outgoing value |
| bus_dout_en | output | 1 | Data pin driver enable |
| bus_din | input | DW | Data pins, incoming value |

## Verification
Random level tables and random phase counts make every phase visible at the pins. A wrong phase length, wrong phase order or wrong table index therefore shows up as a strobe mismatch in a specific cycle. Reads drive a different value on `bus_din` in every cycle except the last data wait cycle, so sampling one cycle early or late returns the wrong data. Random multiplexed, non-multiplexed, 8-bit and 16-bit runs separate the address phases from the data phases on the data pins. Directed runs cover all-zero and all-maximum counts, the skipped write data hold, writes refused in read-only mode, a second start issued while busy, and the delayed output enable with keep-last idling.

// File: rtl/ebus_pkg.sv
package ebus_pkg;
    localparam int CNTW = 6;
    localparam int TIMW = 22;
    localparam int LVLW = 16;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_ASU  = 3'd1,
        PH_AHO  = 3'd2,
        PH_DWT  = 3'd3,
        PH_DHO  = 3'd4
    } phase_e;

    // count for the phase from a timing word
    function automatic logic [CNTW-1:0] phase_len(phase_e ph, logic [TIMW-1:0] t);
        case (ph)
            PH_ASU:  phase_len = {2'b00, t[3:0]};
            PH_AHO:  phase_len = {2'b00, t[7:4]};
            PH_DWT:  phase_len = t[21:16];
            PH_DHO:  phase_len = {2'b00, t[11:8]};
            default: phase_len = '0;
        endcase
    endfunction

    // column of the level table for the phase
    function automatic logic [1:0] phase_idx(phase_e ph);
        case (ph)
            PH_AHO:  phase_idx = 2'd1;
            PH_DWT:  phase_idx = 2'd2;
            PH_DHO:  phase_idx = 2'd3;
            default: phase_idx = 2'd0;
        endcase
    endfunction
endpackage

// File: rtl/ebus_phase_ctrl.sv
module ebus_phase_ctrl
    import ebus_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic            write_i,
    input  logic [AW-1:0]   addr_i,
    input  logic [DW-1:0]   wdata_i,
    input  logic            rdonly_i,
    input  logic            wdh_inh_i,
    input  logic [TIMW-1:0] rd_time_i,
    input  logic [TIMW-1:0] wr_time_i,
    input  logic [DW-1:0]   din_i,
    output phase_e          phase_o,
    output logic            wr_o,
    output logic [AW-1:0]   addr_o,
    output logic [DW-1:0]   wdata_o,
    output logic [DW-1:0]   rdata_o,
    output logic            done_o,
    output logic            err_o
);
    typedef struct packed {
        phase_e          ph;
        logic [CNTW-1:0] cnt;
        logic            wr;
        logic [AW-1:0]   addr;
        logic [DW-1:0]   wdata;
        logic [DW-1:0]   rdata;
        logic            done;
        logic            err;
    } ctrl_t;

    ctrl_t s_d, s_q;
    logic  last_c;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        s_d.err  = 1'b0;
        last_c   = (s_q.cnt == phase_len(s_q.ph, s_q.wr ? wr_time_i : rd_time_i));
        if (s_q.ph == PH_IDLE) begin
            if (start_i) begin
                if (write_i && rdonly_i) begin
                    s_d.done = 1'b1;
                    s_d.err  = 1'b1;
                end else begin
                    s_d.ph    = PH_ASU;
                    s_d.cnt   = '0;
                    s_d.wr    = write_i;
                    s_d.addr  = addr_i;
                    s_d.wdata = wdata_i;
                end
            end
        end else if (!last_c) begin
            s_d.cnt = s_q.cnt + 1'b1;
        end else begin
            s_d.cnt = '0;
            case (s_q.ph)
                PH_ASU: s_d.ph = PH_AHO;
                PH_AHO: s_d.ph = PH_DWT;
                PH_DWT: begin
                    if (!s_q.wr) s_d.rdata = din_i;
                    if (s_q.wr && wdh_inh_i) begin
                        s_d.ph   = PH_IDLE;
                        s_d.done = 1'b1;
                    end else begin
                        s_d.ph = PH_DHO;
                    end
                end
                default: begin
                    s_d.ph   = PH_IDLE;
                    s_d.done = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{ph: PH_IDLE, default: '0};
        else        s_q <= s_d;
    end

    assign phase_o = s_q.ph;
    assign wr_o    = s_q.wr;
    assign addr_o  = s_q.addr;
    assign wdata_o = s_q.wdata;
    assign rdata_o = s_q.rdata;
    assign done_o  = s_q.done;
    assign err_o   = s_q.err;
endmodule

// File: rtl/ebus_pin_drive.sv
module ebus_pin_drive
    import ebus_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  phase_e          phase_i,
    input  logic            wr_i,
    input  logic [LVLW-1:0] rd_lv_i,
    input  logic [LVLW-1:0] wr_lv_i,
    input  logic            oe_delay_i,
    input  logic            mux_i,
    input  logic            keep_i,
    input  logic [DW-1:0]   abus_i,
    input  logic [DW-1:0]   wdata_i,
    input  logic [DW-1:0]   rdata_i,
    output logic            cs_n_o,
    output logic            oe_n_o,
    output logic            wr_n_o,
    output logic            ale_o,
    output logic [DW-1:0]   dout_o,
    output logic            dout_en_o
);
    localparam int NSTB = 4;

    logic [LVLW-1:0] lv;
    logic [1:0]      pidx;
    logic            active;
    logic [NSTB-1:0] tab;
    logic            oe_prev_d, oe_prev_q;

    assign lv     = wr_i ? wr_lv_i : rd_lv_i;
    assign pidx   = phase_idx(phase_i);
    assign active = (phase_i != PH_IDLE);

    for (genvar s = 0; s < NSTB; s++) begin : g_stb
        assign tab[s] = active ? lv[s*NSTB + int'(pidx)] : 1'b1;
    end

    always_comb begin
        oe_prev_d = active && !tab[1];
        cs_n_o    = tab[0];
        oe_n_o    = tab[1] | (oe_delay_i & !oe_prev_q);
        wr_n_o    = tab[2];
        ale_o     = tab[3];
        dout_o    = '0;
        dout_en_o = 1'b0;
        if (!active) begin
            dout_en_o = keep_i;
            dout_o    = keep_i ? rdata_i : '0;
        end else if (mux_i && (phase_i == PH_ASU || phase_i == PH_AHO)) begin
            dout_en_o = 1'b1;
            dout_o    = abus_i;
        end else if (wr_i) begin
            dout_en_o = 1'b1;
            dout_o    = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) oe_prev_q <= 1'b0;
        else        oe_prev_q <= oe_prev_d;
    end
endmodule

// File: rtl/ebus_seq.sv
module ebus_seq
    import ebus_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_start,
    input  logic            req_write,
    input  logic [AW-1:0]   req_addr,
    input  logic [DW-1:0]   req_wdata,
    output logic [DW-1:0]   req_rdata,
    output logic            req_done,
    output logic            req_err,
    input  logic            cfg_wide,
    input  logic            cfg_mux,
    input  logic            cfg_ashift,
    input  logic            cfg_rdonly,
    input  logic            cfg_wdh_inhibit,
    input  logic            cfg_oe_delay,
    input  logic            cfg_keep_last,
    input  logic [TIMW-1:0] cfg_rd_timing,
    input  logic [TIMW-1:0] cfg_wr_timing,
    input  logic [LVLW-1:0] cfg_rd_levels,
    input  logic [LVLW-1:0] cfg_wr_levels,
    output logic            bus_cs_n,
    output logic            bus_oe_n,
    output logic            bus_wr_n,
    output logic            bus_ale,
    output logic [AW-1:0]   bus_addr,
    output logic [DW-1:0]   bus_dout,
    output logic            bus_dout_en,
    input  logic [DW-1:0]   bus_din
);
    localparam int HW = DW / 2;

    phase_e        phase_w;
    logic          wr_w;
    logic [AW-1:0] addr_w;
    logic [DW-1:0] wdata_w, din_m, abus_m, wdata_m;

    function automatic logic [DW-1:0] narrow(logic [DW-1:0] v, logic wide);
        return wide ? v : {{(DW-HW){1'b0}}, v[HW-1:0]};
    endfunction

    assign din_m    = narrow(bus_din, cfg_wide);
    assign bus_addr = (cfg_wide && cfg_ashift) ? (addr_w >> 1) : addr_w;
    assign abus_m   = narrow(bus_addr[DW-1:0], cfg_wide);
    assign wdata_m  = narrow(wdata_w, cfg_wide);

    ebus_phase_ctrl #(.AW(AW), .DW(DW)) ctrl_i (
        .clk(clk), .rst_n(rst_n),
        .start_i(req_start), .write_i(req_write),
        .addr_i(req_addr), .wdata_i(req_wdata),
        .rdonly_i(cfg_rdonly), .wdh_inh_i(cfg_wdh_inhibit),
        .rd_time_i(cfg_rd_timing), .wr_time_i(cfg_wr_timing),
        .din_i(din_m),
        .phase_o(phase_w), .wr_o(wr_w), .addr_o(addr_w), .wdata_o(wdata_w),
        .rdata_o(req_rdata), .done_o(req_done), .err_o(req_err)
    );

    ebus_pin_drive #(.DW(DW)) pins_i (
        .clk(clk), .rst_n(rst_n),
        .phase_i(phase_w), .wr_i(wr_w),
        .rd_lv_i(cfg_rd_levels), .wr_lv_i(cfg_wr_levels),
        .oe_delay_i(cfg_oe_delay), .mux_i(cfg_mux), .keep_i(cfg_keep_last),
        .abus_i(abus_m), .wdata_i(wdata_m), .rdata_i(req_rdata),
        .cs_n_o(bus_cs_n), .oe_n_o(bus_oe_n), .wr_n_o(bus_wr_n), .ale_o(bus_ale),
        .dout_o(bus_dout), .dout_en_o(bus_dout_en)
    );
endmodule

// File: rtl/ebus_seq_chk.sv
module ebus_seq_chk
    import ebus_pkg::*;
(
    input logic   clk,
    input logic   rst_n,
    input phase_e phase,
    input logic   is_wr,
    input logic   cfg_wdh_inhibit,
    input logic   cfg_mux,
    input logic   cfg_keep_last,
    input logic   bus_cs_n,
    input logic   bus_oe_n,
    input logic   bus_wr_n,
    input logic   bus_ale,
    input logic   bus_dout_en,
    input logic   req_done,
    input logic   req_err
);
    a_r1_idle_strobes: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE) |-> ({bus_cs_n, bus_oe_n, bus_wr_n, bus_ale} == 4'hF));

    a_r7_idle_release: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE && !cfg_keep_last) |-> !bus_dout_en);

    a_r5_done_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        req_done |-> (phase == PH_IDLE));

    a_r8_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |-> req_done);

    a_r6_no_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DHO) |-> !(is_wr && cfg_wdh_inhibit));

    a_r2_hold_after_setup: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_AHO && $past(phase) != PH_AHO) |-> ($past(phase) == PH_ASU));

    a_r9_mux_addr_driven: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mux && (phase == PH_ASU || phase == PH_AHO)) |-> bus_dout_en);
endmodule

bind ebus_seq ebus_seq_chk chk_i (
    .clk(clk), .rst_n(rst_n), .phase(phase_w), .is_wr(wr_w),
    .cfg_wdh_inhibit(cfg_wdh_inhibit), .cfg_mux(cfg_mux),
    .cfg_keep_last(cfg_keep_last),
    .bus_cs_n(bus_cs_n), .bus_oe_n(bus_oe_n), .bus_wr_n(bus_wr_n),
    .bus_ale(bus_ale), .bus_dout_en(bus_dout_en),
    .req_done(req_done), .req_err(req_err)
);

// File: tb/ebus_seq_tb_top.sv
`timescale 1ns/1ps
module ebus_seq_tb_top;
    localparam int AW = 16;
    localparam int DW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic          req_start = 0, req_write = 0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0, req_rdata, bus_dout, bus_din = '0;
    logic          req_done, req_err;
    logic cfg_wide = 0, cfg_mux = 0, cfg_ashift = 0, cfg_rdonly = 0;
    logic cfg_wdh_inhibit = 0, cfg_oe_delay = 0, cfg_keep_last = 0;
    logic [21:0] cfg_rd_timing = '0, cfg_wr_timing = '0;
    logic [15:0] cfg_rd_levels = '1, cfg_wr_levels = '1;
    logic bus_cs_n, bus_oe_n, bus_wr_n, bus_ale, bus_dout_en;
    logic [AW-1:0] bus_addr;

    int errs = 0, checks = 0;
    logic [DW-1:0] last_rd = '0;

    ebus_seq #(.AW(AW), .DW(DW)) dut_i (.*);

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [5:0] dur(logic [21:0] t, int p);
        case (p)
            0: return {2'b0, t[3:0]};
            1: return {2'b0, t[7:4]};
            2: return t[21:16];
            default: return {2'b0, t[11:8]};
        endcase
    endfunction

    function automatic logic [DW-1:0] nar(logic [DW-1:0] v);
        return cfg_wide ? v : {8'h00, v[7:0]};
    endfunction

    task automatic chk_idle(string tag);
        chk({tag, " R1 strobes"}, {bus_cs_n, bus_oe_n, bus_wr_n, bus_ale}, 4'hF);
        chk({tag, " R7 idle en"}, bus_dout_en, cfg_keep_last);
        if (cfg_keep_last) chk({tag, " R7 idle value"}, bus_dout, last_rd);
    endtask

    // one request, checked cycle by cycle at the falling edge
    task automatic run_txn(bit wr, bit poke);
        logic [21:0] t;
        logic [15:0] lv;
        logic [AW-1:0] a, ae;
        logic [DW-1:0] w, rv, dexp;
        bit prev_low, en_exp, tab_oe;
        int k;
        t  = wr ? cfg_wr_timing : cfg_rd_timing;
        lv = wr ? cfg_wr_levels : cfg_rd_levels;
        a  = AW'($urandom);
        w  = DW'($urandom);
        rv = DW'($urandom);
        ae = (cfg_wide && cfg_ashift) ? (a >> 1) : a;
        @(negedge clk);
        req_start = 1; req_write = wr; req_addr = a; req_wdata = w;
        @(posedge clk);
        @(negedge clk);
        prev_low = 0;
        k = 0;
        for (int p = 0; p < 4; p++) begin
            if (p == 3 && wr && cfg_wdh_inhibit) break;
            for (int c = 0; c <= int'(dur(t, p)); c++) begin
                req_start = (poke && k == 1);
                req_write = ~wr;
                tab_oe = lv[4 + p];
                chk("R3 strobes", {bus_cs_n, bus_wr_n, bus_ale},
                    {lv[p], lv[8 + p], lv[12 + p]});
                chk("R10 oe", bus_oe_n, tab_oe | (cfg_oe_delay & !prev_low));
                chk("R5 done low", {req_done, req_err}, 2'b00);
                chk("R11 addr", bus_addr, ae);
                if (cfg_mux && p < 2) begin en_exp = 1; dexp = nar(ae[DW-1:0]); end
                else if (wr) begin en_exp = 1; dexp = nar(w); end
                else begin en_exp = 0; dexp = '0; end
                chk("R9 data en", bus_dout_en, en_exp);
                if (en_exp) chk("R9 R11 data", bus_dout, dexp);
                prev_low = !tab_oe;
                bus_din = (p == 2 && c == int'(dur(t, p))) ? rv : ~rv;
                @(posedge clk);
                @(negedge clk);
                k++;
            end
        end
        req_start = 0;
        chk("R2 R5 R6 done", {req_done, req_err}, 2'b10);
        if (!wr) begin
            last_rd = nar(rv);
            chk("R4 rdata", req_rdata, last_rd);
        end
        chk_idle("after txn");
        @(negedge clk);
        chk("R5 single done", req_done, 1'b0);
    endtask

    task automatic rnd_cfg();
        cfg_mux = 1'($urandom); cfg_wide = cfg_mux & 1'($urandom);
        cfg_ashift = 1'($urandom); cfg_wdh_inhibit = 1'($urandom);
        cfg_oe_delay = 1'($urandom); cfg_keep_last = 1'($urandom);
        cfg_rd_timing = 22'($urandom) & 22'h0F_0FFF;
        cfg_wr_timing = 22'($urandom) & 22'h0F_0FFF;
        cfg_rd_levels = 16'($urandom); cfg_wr_levels = 16'($urandom);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin : main
        void'($urandom(32'h1234_5EED));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 reset done", {req_done, req_err}, 2'b00);
        chk_idle("reset");

        // zero counts, plain read and write
        cfg_rd_levels = 16'h5A3C; cfg_wr_levels = 16'hC3A5;
        run_txn(0, 0);
        run_txn(1, 0);
        // maximum counts, 16-bit multiplexed with shift
        cfg_mux = 1; cfg_wide = 1; cfg_ashift = 1;
        cfg_rd_timing = 22'h3F_0FFF; cfg_wr_timing = 22'h3F_0FFF;
        run_txn(0, 0);
        run_txn(1, 0);
        // skipped write data hold, reads unaffected
        cfg_wdh_inhibit = 1; cfg_wr_timing = 22'h02_0312; cfg_rd_timing = 22'h02_0312;
        run_txn(1, 0);
        run_txn(0, 0);
        // delayed OE with a long low stretch, keep last
        cfg_oe_delay = 1; cfg_keep_last = 1; cfg_rd_levels = 16'hF00F;
        cfg_rd_timing = 22'h02_1221;
        run_txn(0, 0);
        // start while busy is ignored
        run_txn(0, 1);
        // R8 read-only refuses writes
        cfg_rdonly = 1;
        @(negedge clk);
        req_start = 1; req_write = 1;
        @(posedge clk);
        @(negedge clk);
        req_start = 0;
        chk("R8 err pulse", {req_done, req_err}, 2'b11);
        chk_idle("R8 no activity");
        @(negedge clk);
        chk("R8 err single", {req_done, req_err}, 2'b00);
        chk_idle("R8 still idle");
        run_txn(0, 0);
        cfg_rdonly = 0;
        // 8-bit non-multiplexed
        cfg_mux = 0; cfg_wide = 0; cfg_keep_last = 1;
        run_txn(0, 0);
        run_txn(1, 0);

        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            rnd_cfg();
            run_txn(1'($urandom), (i % 7) == 3);
        end

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule